// File: doc/BRIEF.md
# Set-Associative Read/Write Cache with Least-Recently-Used Replacement

This block sits between a processor-side request port and a memory-side line port. Each request names a word address. The block splits that address into a word offset, a set index and a tag. It reads every way of the chosen set in the same cycle and compares all the tags at once, with one comparator per way. A read hit returns the word in the next cycle and the block stays ready for the next request. On a read miss the block drops ready. It fetches the whole line from memory through a request/acknowledge handshake, installs the line in a victim way, and then returns the requested word.

Stores are write-through with no allocation on a write miss. Every store goes to memory as a single word. A store that hits also updates the cached copy, so the cache never holds data that differs from memory and no line is ever written back. The victim for a fill is the lowest-numbered invalid way of the set if there is one. Otherwise it is the way that has gone unused the longest. For two ways the recency state is a single bit per set. For more ways it is a small age rank per way. The way count, set count, line length and word and address widths are all parameters.

Top module: `assoc_cache`

## Requirements
- R1: The word offset is the low log2(LINE_WORDS) bits of the address. The block number is the address divided by LINE_WORDS. The set index is the block number modulo SETS, and the tag is the remaining upper bits. Blocks in different sets never evict each other.
- R2: A read that matches a valid way of its set gives cpu_valid=1, cpu_hit=1 and the addressed word on cpu_rdata in the cycle after the request is accepted. cpu_ready stays 1 through this.
- R3: A read miss drops cpu_ready in the cycle after acceptance. It raises mem_req with mem_we=0 and a line-aligned mem_addr (offset bits zero). After mem_ack it returns the requested word from the fetched line, with cpu_valid=1, cpu_hit=0 and cpu_ready=1 in the same cycle. cpu_valid stays 0 while cpu_ready is 0.
- R4: A fill goes into the lowest-numbered invalid way of the set whenever one exists.
- R5: When every way of the set is valid, a fill replaces the way whose last hit or fill is the oldest. Read hits, write hits and fills all count as use.
- R6: With two sets, the block sequence 0, 8, 0, 6, 8 gives 4 read misses in a 2-way build and 3 read misses in a 4-way build.
- R7: Every store, hit or miss, issues one memory write (mem_we=1) of cpu_wdata to the word address cpu_addr. A store hit also updates the cached word. A store miss allocates nothing. The store completes with cpu_valid=1 and cpu_hit equal to the lookup result once mem_ack arrives.
- R8: Synchronous reset clears all valid bits and all recency state. After reset cpu_ready=1, cpu_valid=0 and mem_req=0, and the first access to any block misses.
- R9: Only one memory transfer is outstanding at a time. mem_req, mem_we and mem_addr stay stable until mem_ack. Each read miss causes exactly one line read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request strobe, taken when cpu_ready is 1 |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Block can take a request |
| cpu_valid | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Lookup result, valid with cpu_valid |
| cpu_rdata | output | DATA_W | Load data, valid with cpu_valid on loads |
| mem_req | output | 1 | Memory transfer request, held until mem_ack |
| mem_we | output | 1 | 1 = word write, 0 = line read |
| mem_addr | output | ADDR_W | Word address of the transfer (line-aligned for reads) |
| mem_wdata | output | DATA_W | Word to write |
| mem_ack | input | 1 | One-cycle completion from memory |
| mem_rline | input | DATA_W*LINE_WORDS | Fetched line, word 0 in the low bits, valid with mem_ack |

## Verification
The bench builds two copies side by side from the same request stream. Both use two sets and two-word lines. One copy has 2 ways and the other has 4 ways. With only two sets, a handful of block numbers is enough to force conflicts in the same set. That makes the single-bit recency choice and the full four-rank aging order in a filled set easy to reach. It also lets the invalid-way-first rule be seen after reset, and lets the 0, 8, 0, 6, 8 miss counts be compared between the two associativities.

// File: rtl/assoc_cache_pkg.sv
package assoc_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WRITE = 2'd2
  } cstate_e;
endpackage

// File: rtl/tag_compare.sv
module tag_compare #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 20,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       way_valid,
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] match;

  // one comparator per way, all evaluated in the same cycle
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == look_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i]) hit_way = WAY_W'(i);
    end
  end
endmodule

// File: rtl/victim_select.sv
module victim_select #(
  parameter int WAYS  = 2,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAY_W-1:0] lru_way,
  output logic [WAY_W-1:0] victim
);
  // lowest-numbered empty way wins; otherwise the recency choice
  always_comb begin
    victim = lru_way;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!way_valid[i]) victim = WAY_W'(i);
    end
  end
endmodule

// File: rtl/lru_tracker.sv
module lru_tracker #(
  parameter int WAYS  = 2,
  parameter int SETS  = 32,
  parameter int WAY_W = $clog2(WAYS),
  parameter int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_set,
  input  logic             touch_en,
  input  logic [IDX_W-1:0] touch_set,
  input  logic [WAY_W-1:0] touch_way,
  input  logic             touch_fresh,
  output logic [WAY_W-1:0] lru_way
);
  if (WAYS == 2) begin : g_bit
    // one bit per set naming the way to replace next
    logic [SETS-1:0] lru_bit;
    logic unused_fresh;
    assign unused_fresh = touch_fresh;

    always_ff @(posedge clk) begin
      if (rst) begin
        lru_bit <= '0;
      end else if (touch_en) begin
        lru_bit[touch_set] <= ~touch_way[0];
      end
    end

    assign lru_way = lru_bit[look_set];
  end else begin : g_age
    // age rank per way: 0 = most recent, WAYS-1 = oldest
    localparam logic [WAY_W-1:0] AGE_MAX = WAY_W'(WAYS - 1);
    logic [WAY_W-1:0] age [SETS][WAYS];

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int s = 0; s < SETS; s++) begin
          for (int j = 0; j < WAYS; j++) age[s][j] <= '0;
        end
      end else if (touch_en) begin
        for (int j = 0; j < WAYS; j++) begin
          if (WAY_W'(j) == touch_way) begin
            age[touch_set][j] <= '0;
          end else if ((touch_fresh || (age[touch_set][j] < age[touch_set][touch_way]))
                       && (age[touch_set][j] != AGE_MAX)) begin
            age[touch_set][j] <= age[touch_set][j] + 1'b1;
          end
        end
      end
    end

    always_comb begin
      lru_way = '0;
      for (int j = 0; j < WAYS; j++) begin
        if (age[look_set][j] == AGE_MAX) lru_way = WAY_W'(j);
      end
    end
  end
endmodule

// File: rtl/assoc_cache.sv
module assoc_cache
  import assoc_cache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WAYS       = 2,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [DATA_W-1:0]            cpu_wdata,
  output logic                         cpu_ready,
  output logic                         cpu_valid,
  output logic                         cpu_hit,
  output logic [DATA_W-1:0]            cpu_rdata,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic                         mem_ack,
  input  logic [DATA_W*LINE_WORDS-1:0] mem_rline
);
  localparam int OFFS_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int LINE_W = DATA_W * LINE_WORDS;

  // request address fields
  logic [OFFS_W-1:0] req_off;
  logic [IDX_W-1:0]  req_idx;
  logic [TAG_W-1:0]  req_tag;
  assign req_off = cpu_addr[OFFS_W-1:0];
  assign req_idx = cpu_addr[OFFS_W +: IDX_W];
  assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];

  // miss context latched at acceptance
  cstate_e           state;
  logic [ADDR_W-1:0] lat_addr;
  logic [WAY_W-1:0]  vict_q;
  logic              vict_fresh_q;
  logic              whit_q;
  logic [OFFS_W-1:0] lat_off;
  logic [IDX_W-1:0]  lat_idx;
  logic [TAG_W-1:0]  lat_tag;
  assign lat_off = lat_addr[OFFS_W-1:0];
  assign lat_idx = lat_addr[OFFS_W +: IDX_W];
  assign lat_tag = lat_addr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]       way_valid;
  logic [WAYS*TAG_W-1:0] way_tags;
  logic [LINE_W-1:0]     way_line [WAYS];
  logic                  hit;
  logic [WAY_W-1:0]      hit_way;
  logic [WAY_W-1:0]      lru_way;
  logic [WAY_W-1:0]      victim;
  logic                  look_go;
  logic                  fill_go;
  logic                  whit_go;

  assign look_go = (state == ST_IDLE) && cpu_req;
  assign fill_go = (state == ST_FILL) && mem_ack;
  assign whit_go = look_go && cpu_we && hit;

  // per-way storage: valid bits in flops, tags and lines as plain arrays
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [SETS-1:0]   vbits;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];
    logic              sel_fill;
    logic              sel_wr;

    assign sel_fill = fill_go && (vict_q == WAY_W'(w));
    assign sel_wr   = whit_go && (hit_way == WAY_W'(w));

    always_ff @(posedge clk) begin
      if (rst) begin
        vbits <= '0;
      end else if (sel_fill) begin
        vbits[lat_idx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (sel_fill) tag_mem[lat_idx] <= lat_tag;
    end

    always_ff @(posedge clk) begin
      if (sel_fill) begin
        line_mem[lat_idx] <= mem_rline;
      end else if (sel_wr) begin
        line_mem[req_idx][int'(req_off)*DATA_W +: DATA_W] <= cpu_wdata;
      end
    end

    assign way_valid[w]                 = vbits[req_idx];
    assign way_tags[w*TAG_W +: TAG_W]   = tag_mem[req_idx];
    assign way_line[w]                  = line_mem[req_idx];
  end

  tag_compare #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) i_cmp (
    .way_valid (way_valid),
    .way_tags  (way_tags),
    .look_tag  (req_tag),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  lru_tracker #(.WAYS(WAYS), .SETS(SETS), .WAY_W(WAY_W), .IDX_W(IDX_W)) i_lru (
    .clk         (clk),
    .rst         (rst),
    .look_set    (req_idx),
    .touch_en    ((look_go && hit) || fill_go),
    .touch_set   (fill_go ? lat_idx : req_idx),
    .touch_way   (fill_go ? vict_q : hit_way),
    .touch_fresh (fill_go ? vict_fresh_q : 1'b0),
    .lru_way     (lru_way)
  );

  victim_select #(.WAYS(WAYS), .WAY_W(WAY_W)) i_vict (
    .way_valid (way_valid),
    .lru_way   (lru_way),
    .victim    (victim)
  );

  logic [LINE_W-1:0] hit_line;
  assign hit_line = way_line[hit_way];

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cpu_ready    <= 1'b1;
      cpu_valid    <= 1'b0;
      cpu_hit      <= 1'b0;
      cpu_rdata    <= '0;
      mem_req      <= 1'b0;
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      lat_addr     <= '0;
      vict_q       <= '0;
      vict_fresh_q <= 1'b0;
      whit_q       <= 1'b0;
    end else begin
      cpu_valid <= 1'b0;
      cpu_hit   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cpu_req) begin
            if (!cpu_we) begin
              if (hit) begin
                cpu_valid <= 1'b1;
                cpu_hit   <= 1'b1;
                cpu_rdata <= hit_line[int'(req_off)*DATA_W +: DATA_W];
              end else begin
                state        <= ST_FILL;
                cpu_ready    <= 1'b0;
                mem_req      <= 1'b1;
                mem_we       <= 1'b0;
                mem_addr     <= {cpu_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
                lat_addr     <= cpu_addr;
                vict_q       <= victim;
                vict_fresh_q <= !way_valid[victim];
              end
            end else begin
              state     <= ST_WRITE;
              cpu_ready <= 1'b0;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= cpu_addr;
              mem_wdata <= cpu_wdata;
              whit_q    <= hit;
            end
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            state     <= ST_IDLE;
            mem_req   <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_valid <= 1'b1;
            cpu_rdata <= mem_rline[int'(lat_off)*DATA_W +: DATA_W];
          end
        end
        ST_WRITE: begin
          if (mem_ack) begin
            state     <= ST_IDLE;
            mem_req   <= 1'b0;
            mem_we    <= 1'b0;
            cpu_ready <= 1'b1;
            cpu_valid <= 1'b1;
            cpu_hit   <= whit_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/assoc_cache_chk.sv
module assoc_cache_chk #(
  parameter int ADDR_W = 32,
  parameter int OFFS_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_ready,
  input logic              cpu_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  // accepted request either answers next cycle or stalls
  p_accept_answer_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> (cpu_valid || !cpu_ready))
    else $error("accepted request neither answered nor stalled");

  p_stall_fetch_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(cpu_ready) |-> mem_req)
    else $error("stall without memory request");

  p_quiet_busy_r3: assert property (@(posedge clk) disable iff (rst)
    !cpu_ready |-> !cpu_valid)
    else $error("response while stalled");

  p_line_align_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr[OFFS_W-1:0] == '0))
    else $error("line read not aligned");

  p_resume_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (cpu_ready && cpu_valid && !mem_req))
    else $error("no completion after memory acknowledge");

  p_hold_req_r9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)))
    else $error("memory request changed before acknowledge");

  p_reset_state_r8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cpu_ready && !cpu_valid && !mem_req))
    else $error("wrong state after reset");
endmodule

bind assoc_cache assoc_cache_chk #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_ready (cpu_ready),
  .cpu_valid (cpu_valid),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr)
);

// File: tb/test_assoc_cache.sv
`timescale 1ns/1ps
module test_assoc_cache;
  localparam int MEM_LAT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        c_req = 1'b0, c_we = 1'b0;
  logic [15:0] c_addr = '0;
  logic [31:0] c_wdata = '0;

  logic a_rdy, a_val, a_hit, a_mreq, a_mwe, a_mack;
  logic [31:0] a_rdata, a_mwdata;
  logic [15:0] a_maddr;
  logic [63:0] a_mline;
  logic b_rdy, b_val, b_hit, b_mreq, b_mwe, b_mack;
  logic [31:0] b_rdata, b_mwdata;
  logic [15:0] b_maddr;
  logic [63:0] b_mline;

  assoc_cache #(.ADDR_W(16), .DATA_W(32), .WAYS(2), .SETS(2), .LINE_WORDS(2)) i_assoc_cache (
    .clk(clk), .rst(rst), .cpu_req(c_req), .cpu_we(c_we), .cpu_addr(c_addr),
    .cpu_wdata(c_wdata), .cpu_ready(a_rdy), .cpu_valid(a_val), .cpu_hit(a_hit),
    .cpu_rdata(a_rdata), .mem_req(a_mreq), .mem_we(a_mwe), .mem_addr(a_maddr),
    .mem_wdata(a_mwdata), .mem_ack(a_mack), .mem_rline(a_mline));

  assoc_cache #(.ADDR_W(16), .DATA_W(32), .WAYS(4), .SETS(2), .LINE_WORDS(2)) i_assoc_cache_w4 (
    .clk(clk), .rst(rst), .cpu_req(c_req), .cpu_we(c_we), .cpu_addr(c_addr),
    .cpu_wdata(c_wdata), .cpu_ready(b_rdy), .cpu_valid(b_val), .cpu_hit(b_hit),
    .cpu_rdata(b_rdata), .mem_req(b_mreq), .mem_we(b_mwe), .mem_addr(b_maddr),
    .mem_wdata(b_mwdata), .mem_ack(b_mack), .mem_rline(b_mline));

  int nchk = 0, nfail = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // backing store shared by both memory models
  logic [31:0] store [int];
  function automatic logic [31:0] word_at(input logic [15:0] a);
    if (store.exists(int'(a))) return store[int'(a)];
    return {16'hD00D, a};
  endfunction

  task automatic chk(input bit ok, input string tg, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // memory responders, driven away from the active edge
  int a_cnt = 0, b_cnt = 0, a_mrd = 0, b_mrd = 0;
  initial begin
    a_mack = 1'b0; a_mline = '0;
    forever begin
      @(negedge clk);
      if (a_mack) a_mack = 1'b0;
      else if (a_mreq && !rst) begin
        a_cnt++;
        if (a_cnt == MEM_LAT) begin
          a_cnt = 0; a_mack = 1'b1;
          if (a_mwe) store[int'(a_maddr)] = a_mwdata;
          else begin
            a_mrd++;
            for (int k = 0; k < 2; k++) a_mline[k*32 +: 32] = word_at(a_maddr + 16'(k));
          end
        end
      end
    end
  end
  initial begin
    b_mack = 1'b0; b_mline = '0;
    forever begin
      @(negedge clk);
      if (b_mack) b_mack = 1'b0;
      else if (b_mreq && !rst) begin
        b_cnt++;
        if (b_cnt == MEM_LAT) begin
          b_cnt = 0; b_mack = 1'b1;
          if (b_mwe) store[int'(b_maddr)] = b_mwdata;
          else begin
            b_mrd++;
            for (int k = 0; k < 2; k++) b_mline[k*32 +: 32] = word_at(b_maddr + 16'(k));
          end
        end
      end
    end
  end

  // reference recency lists: inst, set, position (0 = most recent)
  int ord [2][2][4];
  int occ [2][2];
  task automatic ref_clear();
    for (int i = 0; i < 2; i++) for (int s = 0; s < 2; s++) occ[i][s] = 0;
  endtask
  task automatic ref_step(input int inst, input int ways, input int blk,
                          input bit wr, output bit hit);
    int s, p;
    s = blk % 2; p = -1;
    for (int i = 0; i < occ[inst][s]; i++) if (ord[inst][s][i] == blk) p = i;
    hit = (p >= 0);
    if (hit) begin
      for (int i = p; i > 0; i--) ord[inst][s][i] = ord[inst][s][i-1];
      ord[inst][s][0] = blk;
    end else if (!wr) begin
      if (occ[inst][s] < ways) occ[inst][s]++;
      for (int i = occ[inst][s] - 1; i > 0; i--) ord[inst][s][i] = ord[inst][s][i-1];
      ord[inst][s][0] = blk;
    end
  endtask

  typedef struct { bit hit; bit rd; logic [31:0] data; int cyc; } exp_t;
  exp_t  qa[$], qb[$];
  string ta[$], tb[$];
  int a_rmiss = 0, b_rmiss = 0;

  task automatic judge(input string nm, input exp_t e, input string tg,
                       input logic h, input logic [31:0] d);
    chk(h === e.hit, tg, {nm, " hit flag"}, 32'(h), 32'(e.hit));
    if (e.rd) chk(d === e.data, tg, {nm, " read data"}, d, e.data);
    if (e.hit && e.rd) chk(cyc == e.cyc + 1, "R2", {nm, " hit latency"}, cyc - e.cyc, 1);
  endtask

  // monitor: pops expected items as responses appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && a_val) begin
        if (qa.size() == 0) chk(1'b0, "R2", "2-way unexpected response", 1, 0);
        else begin
          exp_t e; string tg;
          e = qa.pop_front(); tg = ta.pop_front();
          if (e.rd && !a_hit) a_rmiss++;
          judge("2-way", e, tg, a_hit, a_rdata);
        end
      end
      if (!rst && b_val) begin
        if (qb.size() == 0) chk(1'b0, "R2", "4-way unexpected response", 1, 0);
        else begin
          exp_t e; string tg;
          e = qb.pop_front(); tg = tb.pop_front();
          if (e.rd && !b_hit) b_rmiss++;
          judge("4-way", e, tg, b_hit, b_rdata);
        end
      end
    end
  end

  // driver: pushes expectations, then issues one request to both copies
  task automatic access(input bit wr, input int blk, input int off,
                        input logic [31:0] wd, input string tg);
    exp_t ea, eb; bit ha, hb; int wa;
    while (!(a_rdy && b_rdy)) @(negedge clk);
    wa = blk * 2 + off;
    ref_step(0, 2, blk, wr, ha);
    ref_step(1, 4, blk, wr, hb);
    ea.hit = ha; ea.rd = !wr; ea.data = word_at(16'(wa)); ea.cyc = cyc;
    eb.hit = hb; eb.rd = !wr; eb.data = ea.data;          eb.cyc = cyc;
    qa.push_back(ea); ta.push_back(tg);
    qb.push_back(eb); tb.push_back(tg);
    c_we = wr; c_addr = 16'(wa); c_wdata = wd; c_req = 1'b1;
    @(negedge clk);
    c_req = 1'b0;
    if (wr || !ha) chk(!a_rdy, tg, "2-way stall", 32'(a_rdy), 0);
    if (wr || !hb) chk(!b_rdy, tg, "4-way stall", 32'(b_rdy), 0);
    while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
  endtask

  task automatic reset_checks(input string tg);
    chk(a_rdy === 1'b1 && b_rdy === 1'b1, tg, "ready after reset", {a_rdy, b_rdy}, 3);
    chk(a_val === 1'b0 && b_val === 1'b0, tg, "valid after reset", {a_val, b_val}, 0);
    chk(a_mreq === 1'b0 && b_mreq === 1'b0, tg, "mem_req after reset", {a_mreq, b_mreq}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    finish_run();
  end

  initial begin
    int am0, bm0;
    logic [15:0] lfsr;
    ref_clear();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    reset_checks("R8");

    // R6: miss counts for 0,8,0,6,8 (all in set 0)
    am0 = a_rmiss; bm0 = b_rmiss;
    access(0, 0, 0, 0, "R6"); access(0, 8, 0, 0, "R6"); access(0, 0, 1, 0, "R6");
    access(0, 6, 0, 0, "R6"); access(0, 8, 1, 0, "R6");
    chk(a_rmiss - am0 == 4, "R6", "2-way misses", a_rmiss - am0, 4);
    chk(b_rmiss - bm0 == 3, "R6", "4-way misses", b_rmiss - bm0, 3);

    // R1: set-0 traffic leaves block 1 (set 1) in place; offsets pick words
    access(0, 1, 1, 0, "R1");
    access(0, 0, 0, 0, "R1"); access(0, 2, 0, 0, "R1");
    access(0, 4, 1, 0, "R1"); access(0, 6, 0, 0, "R1");
    access(0, 1, 0, 0, "R1");
    chk(qa.size() == 0, "R1", "queue drained", qa.size(), 0);

    // R5: aging order in set 1
    access(0, 3, 0, 0, "R5"); access(0, 5, 0, 0, "R5"); access(0, 7, 0, 0, "R5");
    access(0, 1, 1, 0, "R5"); access(0, 9, 0, 0, "R5"); access(0, 3, 1, 0, "R5");
    access(0, 1, 0, 0, "R5"); access(0, 7, 1, 0, "R5"); access(0, 5, 0, 0, "R5");

    // R7: store hit updates line, store miss does not allocate
    access(1, 1, 0, 32'hCAFE_0001, "R7");
    access(0, 1, 0, 0, "R7");
    access(1, 100, 1, 32'hCAFE_0002, "R7");
    access(0, 100, 1, 0, "R7");
    access(0, 100, 0, 0, "R7");

    // R2: mixed traffic over a small block range
    lfsr = 16'hACE1;
    for (int i = 0; i < 60; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:6] == 2'b00) access(1, int'(lfsr[11:8]) % 12, int'(lfsr[4]), {16'hBEE0, lfsr}, "R2");
      else access(0, int'(lfsr[11:8]) % 12, int'(lfsr[4]), 0, "R2");
    end

    // R8: reset mid-run clears every line
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0; ref_clear();
    reset_checks("R8");
    access(0, 0, 0, 0, "R8"); access(0, 0, 1, 0, "R8");

    // R4: empty ways fill before any eviction
    access(0, 2, 0, 0, "R4"); access(0, 4, 0, 0, "R4"); access(0, 6, 1, 0, "R4");
    access(0, 0, 1, 0, "R4"); access(0, 2, 1, 0, "R4");
    access(0, 4, 0, 0, "R4"); access(0, 6, 0, 0, "R4");

    // R9: one line read per read miss
    chk(a_mrd == a_rmiss, "R9", "2-way line reads vs misses", a_mrd, a_rmiss);
    chk(b_mrd == b_rmiss, "R9", "4-way line reads vs misses", b_mrd, b_rmiss);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule